// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared, level-sensitive PCI interrupt request lines (PIRQ A to D) onto sixteen input lines of a legacy interrupt controller. Each PIRQ has a byte-wide routing register in configuration space. The byte names the destination line, or turns the route off. The block keeps a destination-by-PIRQ record of asserted requests, one bit per pair. Each destination output is the OR of its row in that record. The whole record is evaluated again from the current PIRQ levels on every cycle. A routing write therefore takes effect at once: the old destination is released and the new one is driven.

Software reaches the routing bytes through a 32-bit configuration port that uses dword addresses and per-byte enables. A separate helper computes the slot swizzle. From a device number and an INTx pin it gives the PIRQ index that the device's pin is wired to. The swizzle output, the routing read data and the interrupt outputs all come from registers.

Top module: `pirq_router`

## Requirements
- R1: After reset, all four routing bytes read 0x80 and `irq_out` is all zero.
- R2: The routing byte for PIRQ i sits at configuration byte offset 0x60+i, which is dword 0x18 lane i (bits 8i+7:8i). A write changes only the lanes whose `cfg_be` bit is set. A write to any other dword leaves every route unchanged, and reads of other dwords return zero.
- R3: A read returns each stored routing byte with all eight bits intact, including the upper bits. The data appears on `cfg_rdata` one clock after `cfg_rd_en`, and `cfg_rdata` holds its value when no read is requested.
- R4: A routing byte of 16 or more disables that PIRQ. Asserting a disabled PIRQ drives no output.
- R5: `irq_out[d]` is the OR of every asserted PIRQ whose routing byte equals d. A shared destination stays high until all PIRQs routed to it are low.
- R6: `irq_out` follows a change on `pirq_in` one clock later, and not earlier.
- R7: A routing write is reflected on `irq_out` at the clock edge that accepts it. An asserted PIRQ that is moved releases its old destination in the same cycle as it drives the new one.
- R8: `swz_pirq` equals (`swz_intx` + `swz_slot` − 1) mod 4, with INTA..INTD encoded as 0..3, and is registered with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_dw | input | 6 | Configuration dword address (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for the write lanes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| pirq_in | input | 4 | PIRQ A..D levels, bit 0 = A |
| irq_out | output | 16 | Interrupt-controller input levels |
| swz_slot | input | 5 | Device (slot) number for the swizzle |
| swz_intx | input | 2 | INTx pin for the swizzle, 0 = INTA |
| swz_pirq | output | 2 | Swizzled PIRQ index |

## Verification
The bench builds the router with its defaults: four PIRQs, sixteen destinations, a base offset of 0x60 and a reset byte of 0x80. With these values the 15/16 boundary between the last valid destination and the first disabled value can be tested directly, and all four routes share one dword, so every byte-enable lane maps to a route. The swizzle is checked over all 32 slots and all four pins, including slot 0, where the subtraction wraps.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;
  localparam int ROUTE_BYTE_W = 8;
  typedef logic [ROUTE_BYTE_W-1:0] route_byte_t;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_route_pkg::*;
#(
  parameter int          NUM_PIRQ    = 4,
  parameter int          CFG_DW_W    = 6,
  parameter int          ROUTE_BASE  = 'h60,
  parameter route_byte_t ROUTE_RESET = 8'h80
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_wr_en,
  input  logic                           cfg_rd_en,
  input  logic [CFG_DW_W-1:0]            cfg_dw,
  input  logic [3:0]                     cfg_be,
  input  logic [31:0]                    cfg_wdata,
  output logic [31:0]                    cfg_rdata,
  output logic [NUM_PIRQ*ROUTE_BYTE_W-1:0] route_q,
  output logic [NUM_PIRQ*ROUTE_BYTE_W-1:0] route_next
);
  logic [31:0] rd_word;

  for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_route
    localparam int BYTE_OFF = ROUTE_BASE + i;
    localparam int LANE     = BYTE_OFF % 4;
    localparam logic [CFG_DW_W-1:0] DW_IDX = CFG_DW_W'(BYTE_OFF / 4);
    logic hit;
    assign hit = cfg_wr_en && (cfg_dw == DW_IDX) && cfg_be[LANE];
    assign route_next[i*ROUTE_BYTE_W +: ROUTE_BYTE_W] =
      hit ? cfg_wdata[LANE*8 +: 8] : route_q[i*ROUTE_BYTE_W +: ROUTE_BYTE_W];
    always_ff @(posedge clk) begin
      if (rst) route_q[i*ROUTE_BYTE_W +: ROUTE_BYTE_W] <= ROUTE_RESET;
      else     route_q[i*ROUTE_BYTE_W +: ROUTE_BYTE_W] <= route_next[i*ROUTE_BYTE_W +: ROUTE_BYTE_W];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_PIRQ; i++) begin
      if (cfg_dw == CFG_DW_W'((ROUTE_BASE + i) / 4))
        rd_word[((ROUTE_BASE + i) % 4)*8 +: 8] = route_q[i*ROUTE_BYTE_W +: ROUTE_BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            cfg_rdata <= '0;
    else if (cfg_rd_en) cfg_rdata <= rd_word;
  end
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
  import pirq_route_pkg::*;
#(
  parameter int NUM_PIRQ = 4,
  parameter int NUM_DEST = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_PIRQ-1:0]              pirq_in,
  input  logic [NUM_PIRQ*ROUTE_BYTE_W-1:0] route_next,
  output logic [NUM_DEST-1:0]              irq_out
);
  localparam int MAP_W = NUM_DEST * NUM_PIRQ;

  logic [MAP_W-1:0] map_d, map_q;

  // Bit d*NUM_PIRQ+p is set when PIRQ p is high and routed to d.
  // A byte at or above NUM_DEST matches no d, so the route is off.
  for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_pirq
      assign map_d[d*NUM_PIRQ + p] = pirq_in[p] &&
        (route_next[p*ROUTE_BYTE_W +: ROUTE_BYTE_W] == route_byte_t'(d));
    end
    assign irq_out[d] = |map_q[d*NUM_PIRQ +: NUM_PIRQ];
  end

  always_ff @(posedge clk) begin
    if (rst) map_q <= '0;
    else     map_q <= map_d;
  end
endmodule

// File: rtl/pirq_slot_swizzle.sv
module pirq_slot_swizzle #(
  parameter int NUM_PIRQ = 4,
  parameter int SLOT_W   = 5,
  parameter int PIRQ_W   = $clog2(NUM_PIRQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] swz_slot,
  input  logic [PIRQ_W-1:0] swz_intx,
  output logic [PIRQ_W-1:0] swz_pirq
);
  localparam int SUM_W = SLOT_W + 1;
  logic [SUM_W-1:0] sum;

  // Adding NUM_PIRQ-1 is the same as subtracting one modulo NUM_PIRQ.
  assign sum = SUM_W'(swz_slot) + SUM_W'(swz_intx) + SUM_W'(NUM_PIRQ - 1);

  always_ff @(posedge clk) begin
    if (rst) swz_pirq <= '0;
    else     swz_pirq <= sum[PIRQ_W-1:0];
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_route_pkg::*;
#(
  parameter int          NUM_PIRQ    = 4,
  parameter int          NUM_DEST    = 16,
  parameter int          CFG_DW_W    = 6,
  parameter int          SLOT_W      = 5,
  parameter int          ROUTE_BASE  = 'h60,
  parameter route_byte_t ROUTE_RESET = 8'h80,
  parameter int          PIRQ_W      = $clog2(NUM_PIRQ)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr_en,
  input  logic                cfg_rd_en,
  input  logic [CFG_DW_W-1:0] cfg_dw,
  input  logic [3:0]          cfg_be,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [NUM_PIRQ-1:0] pirq_in,
  output logic [NUM_DEST-1:0] irq_out,
  input  logic [SLOT_W-1:0]   swz_slot,
  input  logic [PIRQ_W-1:0]   swz_intx,
  output logic [PIRQ_W-1:0]   swz_pirq
);
  logic [NUM_PIRQ*ROUTE_BYTE_W-1:0] route_q;
  logic [NUM_PIRQ*ROUTE_BYTE_W-1:0] route_next;

  pirq_route_regs #(
    .NUM_PIRQ(NUM_PIRQ), .CFG_DW_W(CFG_DW_W),
    .ROUTE_BASE(ROUTE_BASE), .ROUTE_RESET(ROUTE_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .route_q(route_q), .route_next(route_next)
  );

  pirq_level_map #(
    .NUM_PIRQ(NUM_PIRQ), .NUM_DEST(NUM_DEST)
  ) u_map (
    .clk(clk), .rst(rst), .pirq_in(pirq_in),
    .route_next(route_next), .irq_out(irq_out)
  );

  pirq_slot_swizzle #(
    .NUM_PIRQ(NUM_PIRQ), .SLOT_W(SLOT_W), .PIRQ_W(PIRQ_W)
  ) u_swz (
    .clk(clk), .rst(rst), .swz_slot(swz_slot),
    .swz_intx(swz_intx), .swz_pirq(swz_pirq)
  );
endmodule

// File: rtl/pirq_route_chk.sv
module pirq_route_chk #(
  parameter int          NUM_PIRQ    = 4,
  parameter int          NUM_DEST    = 16,
  parameter logic [7:0]  ROUTE_RESET = 8'h80
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfg_wr_en,
  input logic                    cfg_rd_en,
  input logic [31:0]             cfg_rdata,
  input logic [NUM_PIRQ-1:0]     pirq_in,
  input logic [NUM_DEST-1:0]     irq_out,
  input logic [NUM_PIRQ*8-1:0]   route_q
);
  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int i = 0; i < NUM_PIRQ; i++)
      if (int'(route_q[i*8 +: 8]) < NUM_DEST) all_off = 1'b0;
  end

  // R1: routes come out of reset disabled
  assert_reset_route_R1: assert property (@(posedge clk)
    $past(rst) |-> (route_q == {NUM_PIRQ{ROUTE_RESET}}));

  // R2: routes move only on an accepted write
  assert_route_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr_en |=> $stable(route_q));

  // R3: read data holds when no read is requested
  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd_en |=> $stable(cfg_rdata));

  // R4: with every route off and no write, nothing is driven
  assert_all_off_R4: assert property (@(posedge clk) disable iff (rst)
    (all_off && !cfg_wr_en) |=> (irq_out == '0));

  // R5: each PIRQ reaches at most one destination
  assert_fanout_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_out) <= $countones($past(pirq_in)));

  // R6: no request in means no output a cycle later
  assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (pirq_in == '0) |=> (irq_out == '0));
endmodule

bind pirq_router pirq_route_chk #(
  .NUM_PIRQ(NUM_PIRQ), .NUM_DEST(NUM_DEST), .ROUTE_RESET(ROUTE_RESET)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
  .cfg_rdata(cfg_rdata), .pirq_in(pirq_in), .irq_out(irq_out),
  .route_q(route_q)
);

// File: tb/pirq_router_tb.sv
module pirq_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  pirq_in = '0;
  logic [15:0] irq_out;
  logic [4:0]  swz_slot = '0;
  logic [1:0]  swz_intx = '0;
  logic [1:0]  swz_pirq;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  localparam logic [5:0] RDW = 6'h18;

  always #5 clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pirq_in(pirq_in), .irq_out(irq_out),
    .swz_slot(swz_slot), .swz_intx(swz_intx), .swz_pirq(swz_pirq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(logic [5:0] dw, output logic [31:0] d);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_dw = dw;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic drive(logic [3:0] v);
    @(negedge clk);
    pirq_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq_out after reset", {16'h0, irq_out}, 32'h0);
    rd(RDW, d);
    chk("R1 routes after reset", d, 32'h80808080);
    drive(4'hF);
    chk("R1 disabled at reset", {16'h0, irq_out}, 32'h0);
    drive(4'h0);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    wr(RDW, 4'hF, 32'h0F0B0A05);  // A->5 B->10 C->11 D->15
    rd(RDW, d);
    chk("R3 readback full dword", d, 32'h0F0B0A05);
    drive(4'b0001);
    chk("R5 A to 5", {16'h0, irq_out}, 32'h0020);
    drive(4'b1010);
    chk("R5 B,D to 10,15", {16'h0, irq_out}, 32'h8400);
    drive(4'b0100);
    chk("R5 C to 11", {16'h0, irq_out}, 32'h0800);
    // R6 latency
    @(negedge clk); pirq_in = 4'b0001;
    #2 chk("R6 no change before edge", {16'h0, irq_out}, 32'h0800);
    @(posedge clk); #1;
    chk("R6 change after one edge", {16'h0, irq_out}, 32'h0020);
    drive(4'h0);
  endtask

  task automatic t_bytes;
    logic [31:0] d;
    wr(RDW, 4'b0100, 32'hEE03EEEE);
    rd(RDW, d);
    chk("R2 lane 2 only", d, 32'h0F030A05);
    wr(6'h19, 4'hF, 32'h01010101);
    rd(RDW, d);
    chk("R2 other dword ignored", d, 32'h0F030A05);
    rd(6'h19, d);
    chk("R2 other dword reads zero", d, 32'h0);
    drive(4'b0100);
    chk("R2 C now to 3", {16'h0, irq_out}, 32'h0008);
    drive(4'h0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    wr(RDW, 4'b0001, 32'h00000010);  // A = 16
    drive(4'b0001);
    chk("R4 value 16 disables", {16'h0, irq_out}, 32'h0);
    wr(RDW, 4'b0001, 32'h0000000F);  // A = 15
    chk("R4 value 15 enabled", {16'h0, irq_out}, 32'h8000);
    wr(RDW, 4'b0001, 32'h000000FF);
    chk("R4 value 0xFF disables", {16'h0, irq_out}, 32'h0);
    rd(RDW, d);
    chk("R3 upper bits kept", d[7:0], 32'hFF);
    drive(4'h0);
  endtask

  task automatic t_share;
    wr(RDW, 4'b0011, 32'h00000707);  // A,B -> 7
    drive(4'b0011);
    chk("R5 shared both high", {16'h0, irq_out}, 32'h0080);
    drive(4'b0010);
    chk("R5 shared one high", {16'h0, irq_out}, 32'h0080);
    drive(4'b0000);
    chk("R5 shared none high", {16'h0, irq_out}, 32'h0);
  endtask

  task automatic t_reroute;
    wr(RDW, 4'b0001, 32'h00000002);
    drive(4'b0001);
    chk("R7 before move", {16'h0, irq_out}, 32'h0004);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_dw = RDW; cfg_be = 4'b0001; cfg_wdata = 32'h09;
    #2 chk("R7 old route until edge", {16'h0, irq_out}, 32'h0004);
    @(posedge clk); #1;
    chk("R7 moved at write edge", {16'h0, irq_out}, 32'h0200);
    @(negedge clk); cfg_wr_en = 1'b0; cfg_be = '0;
    wr(RDW, 4'b0001, 32'h00000080);
    chk("R7 disabled by write", {16'h0, irq_out}, 32'h0);
    drive(4'h0);
  endtask

  task automatic t_swizzle;
    for (int s = 0; s < 32; s++) begin
      for (int x = 0; x < 4; x++) begin
        @(negedge clk);
        swz_slot = 5'(s); swz_intx = 2'(x);
        @(negedge clk);
        chk("R8 swizzle", {30'h0, swz_pirq}, 32'(((x + s - 1) % 4 + 4) % 4));
      end
    end
  endtask

  initial begin
    #(200_000 * 10);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_basic;
    t_bytes;
    t_disable;
    t_share;
    t_reroute;
    t_swizzle;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule